// File: doc/BRIEF.md
# I/O Base Relocator with Snooped Unlock

This block holds the 32-bit I/O base address of a bus peripheral and decides whether the peripheral answers I/O cycles at all. After a hardware reset it waits for the configuration-memory reader to finish. If the reader returns a valid image, the block takes the base address from it and starts responding at once. If the memory is absent or its data is bad, the block enters a relocatable mode. In that mode the peripheral claims no access. The block only listens to host write cycles on the bus.

In relocatable mode, software moves the device by writing to one fixed port, 378h. The first four writes there must carry a fixed unlock key. The eight writes that follow carry the new base address and a configuration word. The block then loads the base, drives its response enable high and returns to normal operation. In normal operation the host reads and writes the base as two 16-bit halves.

Top module: `io_base_relocator`

## Requirements
- R1: While `rst` is high and in the cycle after it, `resp_en` is 0, `base_lo`/`base_hi` are 0 and `cfg_word` is 0.
- R2: While waiting after reset, a pulse on `ee_done` with `ee_err`=0 loads `ee_base[15:0]` into `base_lo` and `ee_base[31:16]` into `base_hi`, and raises `resp_en`, all visible one cycle later.
- R3: While waiting after reset, a pulse on `ee_done` with `ee_err`=1 enters relocatable mode: `resp_en` stays 0 and the base stays 0.
- R4: While `resp_en` is 0, host register writes (`host_wr`) have no effect on `base_lo`/`base_hi`.
- R5: In relocatable mode, four snooped writes (`snp_wr`=1, `snp_addr`=378h) whose bytes are `KEY[7:0]`, `KEY[15:8]`, `KEY[23:16]`, `KEY[31:24]` in that order unlock capture.
- R6: A snooped write to 378h whose byte does not match the expected key byte sends the matcher back to the first key byte. That byte does not count as a first key byte.
- R7: Snooped writes to any address other than 378h are ignored. They neither break the unlock sequence nor count as capture bytes.
- R8: After the unlock, the next eight writes to 378h are captured in order. Bytes 0..3 form the base, least-significant first. Bytes 4..7 form `cfg_word`, least-significant first. Nothing changes before the eighth write. One cycle after the eighth write, base, `cfg_word` and `resp_en`=1 are visible.
- R9: While `resp_en` is 1, `host_wr` with `host_sel`=0 writes `base_lo` and with `host_sel`=1 writes `base_hi`. Further `ee_done` pulses and writes to 378h (key or otherwise) have no effect. `resp_en` stays 1 until reset.
- R10: A reset during capture discards the captured bytes and restarts the wait for the memory reader. Relocation then needs a full new unlock.
- R11: A host write in the same cycle as the eighth capture write is ignored. The captured base is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ee_done | input | 1 | One-cycle pulse: memory reader finished |
| ee_err | input | 1 | With `ee_done`: memory absent or data invalid |
| ee_base | input | 32 | Base address field from the memory reader |
| snp_wr | input | 1 | Observed host write cycle on the bus |
| snp_addr | input | 16 | I/O address of the observed write |
| snp_data | input | 8 | Data byte of the observed write |
| host_wr | input | 1 | Host write to a base register |
| host_sel | input | 1 | 0 = low half, 1 = high half |
| host_wdata | input | 16 | Host write data |
| base_lo | output | 16 | Base address bits 15:0 |
| base_hi | output | 16 | Base address bits 31:16 |
| cfg_word | output | 32 | Configuration word from relocation |
| resp_en | output | 1 | Device may claim I/O accesses |

## Verification
Two events can fall on the same cycle: the eighth capture write and a host register write. The eighth write loads the base from the snooped bytes, while the host write would overwrite one half of that base. The bench drives both on one clock edge, with random host data and random capture bytes. It then checks that both halves of the base equal the captured bytes and that `resp_en` rises. Unrelated bus writes are also scattered at random through the unlock and capture phases. This shows that only writes to 378h advance the sequence.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_EE = 2'd0,
    ST_NORMAL  = 2'd1,
    ST_UNLOCK  = 2'd2,
    ST_CAPTURE = 2'd3
  } state_e;
endpackage

// File: rtl/reloc_unlock_match.sv
module reloc_unlock_match #(
  parameter int KEY_LEN = 4,
  parameter logic [8*KEY_LEN-1:0] KEY = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       hit,
  input  logic [7:0] data,
  output logic       unlocked
);
  localparam int IW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  logic [IW-1:0] idx;
  logic [7:0]    expect_byte;
  logic          match, last, take;

  assign expect_byte = KEY[{idx, 3'b000} +: 8];
  assign match       = (data == expect_byte);
  assign last        = (idx == IW'(KEY_LEN - 1));
  assign take        = en && hit;
  assign unlocked    = take && match && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (take) begin
      if (!match || last) idx <= '0;
      else                idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/reloc_capture.sv
module reloc_capture #(
  parameter int N_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   hit,
  input  logic [7:0]             data,
  output logic                   done,
  output logic [8*N_BYTES-1:0]   word
);
  localparam int CW = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

  logic [CW-1:0]          cnt;
  logic [8*N_BYTES-1:0]   buffer;
  logic                   take, last;

  assign take = en && hit;
  assign last = (cnt == CW'(N_BYTES - 1));
  assign done = take && last;

  always_comb begin
    word = buffer;
    word[{cnt, 3'b000} +: 8] = data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      buffer <= '0;
    end else if (take) begin
      buffer[{cnt, 3'b000} +: 8] <= data;
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/reloc_base_regs.sv
module reloc_base_regs #(
  parameter int BASE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ee_load,
  input  logic [BASE_W-1:0]   ee_base,
  input  logic                rl_load,
  input  logic [BASE_W-1:0]   rl_base,
  input  logic                host_wr,
  input  logic                host_sel,
  input  logic [BASE_W/2-1:0] host_data,
  output logic [BASE_W-1:0]   base
);
  localparam int HALF = BASE_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
    end else if (rl_load) begin
      base <= rl_base;
    end else if (ee_load) begin
      base <= ee_base;
    end else if (host_wr) begin
      if (host_sel) base[BASE_W-1:HALF] <= host_data;
      else          base[HALF-1:0]      <= host_data;
    end
  end
endmodule

// File: rtl/io_base_relocator.sv
module io_base_relocator #(
  parameter int          ADDR_W     = 16,
  parameter int          BASE_W     = 32,
  parameter int          CFG_W      = 32,
  parameter int          KEY_LEN    = 4,
  parameter logic [31:0] KEY        = 32'h5AA5C33C,
  parameter logic [15:0] SNOOP_ADDR = 16'h0378
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ee_done,
  input  logic                ee_err,
  input  logic [BASE_W-1:0]   ee_base,
  input  logic                snp_wr,
  input  logic [ADDR_W-1:0]   snp_addr,
  input  logic [7:0]          snp_data,
  input  logic                host_wr,
  input  logic                host_sel,
  input  logic [BASE_W/2-1:0] host_wdata,
  output logic [BASE_W/2-1:0] base_lo,
  output logic [BASE_W/2-1:0] base_hi,
  output logic [CFG_W-1:0]    cfg_word,
  output logic                resp_en
);
  import reloc_pkg::*;

  localparam int HALF      = BASE_W / 2;
  localparam int CAP_BYTES = (BASE_W + CFG_W) / 8;
  localparam int CAP_W     = 8 * CAP_BYTES;

  state_e             st;
  logic               snoop_hit, unlocked, cap_done;
  logic [CAP_W-1:0]   cap_word;
  logic [BASE_W-1:0]  base;
  logic               ee_load, host_ok;

  assign snoop_hit = snp_wr && (snp_addr == ADDR_W'(SNOOP_ADDR));
  assign ee_load   = (st == ST_WAIT_EE) && ee_done && !ee_err;
  assign host_ok   = host_wr && (st == ST_NORMAL);

  reloc_unlock_match #(
    .KEY_LEN (KEY_LEN),
    .KEY     (KEY[8*KEY_LEN-1:0])
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .en       (st == ST_UNLOCK),
    .hit      (snoop_hit),
    .data     (snp_data),
    .unlocked (unlocked)
  );

  reloc_capture #(
    .N_BYTES (CAP_BYTES)
  ) u_cap (
    .clk  (clk),
    .rst  (rst),
    .en   (st == ST_CAPTURE),
    .hit  (snoop_hit),
    .data (snp_data),
    .done (cap_done),
    .word (cap_word)
  );

  reloc_base_regs #(
    .BASE_W (BASE_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ee_load   (ee_load),
    .ee_base   (ee_base),
    .rl_load   (cap_done),
    .rl_base   (cap_word[BASE_W-1:0]),
    .host_wr   (host_ok),
    .host_sel  (host_sel),
    .host_data (host_wdata),
    .base      (base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_WAIT_EE;
      resp_en  <= 1'b0;
      cfg_word <= '0;
    end else begin
      case (st)
        ST_WAIT_EE: if (ee_done) begin
          if (ee_err) begin
            st <= ST_UNLOCK;
          end else begin
            st      <= ST_NORMAL;
            resp_en <= 1'b1;
          end
        end
        ST_UNLOCK:  if (unlocked) st <= ST_CAPTURE;
        ST_CAPTURE: if (cap_done) begin
          st       <= ST_NORMAL;
          resp_en  <= 1'b1;
          cfg_word <= cap_word[CAP_W-1:BASE_W];
        end
        default: ;
      endcase
    end
  end

  assign base_lo = base[HALF-1:0];
  assign base_hi = base[BASE_W-1:HALF];
endmodule

// File: rtl/reloc_checker.sv
module reloc_checker #(
  parameter int          ADDR_W     = 16,
  parameter int          BASE_W     = 32,
  parameter int          CFG_W      = 32,
  parameter logic [15:0] SNOOP_ADDR = 16'h0378
) (
  input logic                clk,
  input logic                rst,
  input logic                ee_done,
  input logic                ee_err,
  input logic [BASE_W-1:0]   ee_base,
  input logic                snp_wr,
  input logic [ADDR_W-1:0]   snp_addr,
  input logic [BASE_W/2-1:0] base_lo,
  input logic [BASE_W/2-1:0] base_hi,
  input logic [CFG_W-1:0]    cfg_word,
  input logic                resp_en,
  input reloc_pkg::state_e   st
);
  import reloc_pkg::*;

  logic hit;
  assign hit = snp_wr && (snp_addr == ADDR_W'(SNOOP_ADDR));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!resp_en && base_lo == '0 && base_hi == '0 && cfg_word == '0));

  assert_ee_load_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_EE && ee_done && !ee_err) |=>
      (resp_en && {base_hi, base_lo} == $past(ee_base)));

  assert_ee_err_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_EE && ee_done && ee_err) |=> !resp_en);

  assert_host_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (!resp_en && !hit && !ee_done) |=> $stable({base_hi, base_lo}));

  assert_resp_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    resp_en |=> resp_en);
endmodule

bind io_base_relocator reloc_checker #(
  .ADDR_W     (ADDR_W),
  .BASE_W     (BASE_W),
  .CFG_W      (CFG_W),
  .SNOOP_ADDR (SNOOP_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ee_done  (ee_done),
  .ee_err   (ee_err),
  .ee_base  (ee_base),
  .snp_wr   (snp_wr),
  .snp_addr (snp_addr),
  .base_lo  (base_lo),
  .base_hi  (base_hi),
  .cfg_word (cfg_word),
  .resp_en  (resp_en),
  .st       (st)
);

// File: tb/tb_io_base_relocator.sv
module tb_io_base_relocator;
  localparam logic [31:0] KEY  = 32'h5AA5C33C;
  localparam logic [15:0] PORT = 16'h0378;

  logic        clk = 1'b0;
  logic        rst, ee_done, ee_err, snp_wr, host_wr, host_sel;
  logic [31:0] ee_base;
  logic [15:0] snp_addr, host_wdata;
  logic [7:0]  snp_data;
  logic [15:0] base_lo, base_hi;
  logic [31:0] cfg_word;
  logic        resp_en;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  io_base_relocator dut (
    .clk(clk), .rst(rst), .ee_done(ee_done), .ee_err(ee_err), .ee_base(ee_base),
    .snp_wr(snp_wr), .snp_addr(snp_addr), .snp_data(snp_data),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .base_lo(base_lo), .base_hi(base_hi), .cfg_word(cfg_word), .resp_en(resp_en)
  );

  function automatic logic [7:0] key_byte(input int i);
    return KEY[8*i +: 8];
  endfunction

  function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_inputs();
    ee_done = 0; ee_err = 0; snp_wr = 0; host_wr = 0; host_sel = 0;
    ee_base = '0; snp_addr = '0; snp_data = '0; host_wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic ee_result(input logic err, input logic [31:0] b);
    ee_done = 1; ee_err = err; ee_base = b; tick();
    ee_done = 0; ee_err = 0;
  endtask

  task automatic snoop(input logic [15:0] a, input logic [7:0] d);
    snp_wr = 1; snp_addr = a; snp_data = d; tick(); snp_wr = 0;
  endtask

  task automatic host(input logic sel, input logic [15:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d; tick(); host_wr = 0;
  endtask

  task automatic noise();
    int n = $urandom_range(0, 2);
    for (int k = 0; k < n; k++) begin
      logic [15:0] a = 16'($urandom);
      if (a == PORT) a = a ^ 16'h0001;
      snoop(a, 8'($urandom));
    end
  endtask

  task automatic send_key(input bit with_noise);
    for (int i = 0; i < 4; i++) begin
      if (with_noise) noise();
      snoop(PORT, key_byte(i));
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] model;
    logic [7:0]  cap [8];
    void'($urandom(32'd20240611));
    clear_inputs();
    rst = 1; tick();
    check("R1 resp_en", {31'd0, resp_en}, 32'd0);
    check("R1 base", {base_hi, base_lo}, 32'd0);
    check("R1 cfg", cfg_word, 32'd0);
    rst = 0; tick();

    // R2: good EEPROM image
    model = $urandom;
    ee_result(1'b0, model);
    check("R2 resp_en", {31'd0, resp_en}, 32'd1);
    check("R2 base_lo", {16'd0, base_lo}, {16'd0, model[15:0]});
    check("R2 base_hi", {16'd0, base_hi}, {16'd0, model[31:16]});

    // R9: host writes in normal mode, random
    for (int i = 0; i < 12; i++) begin
      logic        s = 1'($urandom);
      logic [15:0] d = 16'($urandom);
      host(s, d);
      if (s) model[31:16] = d; else model[15:0] = d;
      check("R9 host write", {base_hi, base_lo}, model);
    end
    send_key(0);
    for (int i = 0; i < 8; i++) snoop(PORT, 8'($urandom));
    ee_result(1'b0, ~model);
    check("R9 snoop/ee ignored", {base_hi, base_lo}, model);
    check("R9 resp_en held", {31'd0, resp_en}, 32'd1);

    // R3, R4: error path, host writes blocked
    do_reset();
    ee_result(1'b1, 32'hDEADBEEF);
    check("R3 resp_en", {31'd0, resp_en}, 32'd0);
    check("R3 base", {base_hi, base_lo}, 32'd0);
    host(1'b0, 16'h1234); host(1'b1, 16'h5678);
    check("R4 host blocked", {base_hi, base_lo}, 32'd0);

    // R6: broken sequence (key0, key0, key1, key2, key3) must not unlock
    snoop(PORT, key_byte(0));
    snoop(PORT, key_byte(0));
    snoop(PORT, key_byte(1)); snoop(PORT, key_byte(2)); snoop(PORT, key_byte(3));
    for (int i = 0; i < 8; i++) snoop(PORT, 8'hA0 + 8'(i));
    check("R6 no unlock resp_en", {31'd0, resp_en}, 32'd0);
    check("R6 no unlock base", {base_hi, base_lo}, 32'd0);

    // R5, R7, R8, R11: unlock and capture with noise; host write on 8th byte
    send_key(1);
    for (int i = 0; i < 8; i++) cap[i] = 8'($urandom);
    for (int i = 0; i < 7; i++) begin noise(); snoop(PORT, cap[i]); end
    check("R8 no early load", {base_hi, base_lo}, 32'd0);
    check("R8 no early resp", {31'd0, resp_en}, 32'd0);
    snp_wr = 1; snp_addr = PORT; snp_data = cap[7];
    host_wr = 1; host_sel = 1; host_wdata = 16'($urandom);
    tick();
    snp_wr = 0; host_wr = 0;
    check("R11 base vs host write", {base_hi, base_lo}, pack4(cap[0], cap[1], cap[2], cap[3]));
    check("R8 cfg", cfg_word, pack4(cap[4], cap[5], cap[6], cap[7]));
    check("R5 resp_en", {31'd0, resp_en}, 32'd1);

    // R10: reset mid-capture, then good EEPROM
    do_reset();
    ee_result(1'b1, '0);
    send_key(0);
    for (int i = 0; i < 4; i++) snoop(PORT, 8'h11);
    do_reset();
    check("R10 base cleared", {base_hi, base_lo}, 32'd0);
    model = $urandom;
    ee_result(1'b0, model);
    check("R10 ee restart", {base_hi, base_lo}, model);
    // R10: reset mid-capture, error again: capture bytes alone must not load
    do_reset();
    ee_result(1'b1, '0);
    send_key(0);
    for (int i = 0; i < 3; i++) snoop(PORT, 8'h22);
    do_reset();
    ee_result(1'b1, '0);
    for (int i = 0; i < 8; i++) snoop(PORT, 8'h33);
    check("R10 needs new unlock", {31'd0, resp_en}, 32'd0);

    // Random relocations (R5, R7, R8)
    for (int r = 0; r < 20; r++) begin
      do_reset();
      ee_result(1'b1, 32'($urandom));
      send_key(1);
      for (int i = 0; i < 8; i++) begin
        cap[i] = 8'($urandom);
        noise();
        snoop(PORT, cap[i]);
      end
      check("R8 random base", {base_hi, base_lo}, pack4(cap[0], cap[1], cap[2], cap[3]));
      check("R8 random cfg", cfg_word, pack4(cap[4], cap[5], cap[6], cap[7]));
      check("R7 random resp_en", {31'd0, resp_en}, 32'd1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule